// File: doc/BRIEF.md
# Clockless Interlocked Read Link

This block moves one read across a link on which the two parties share no clock. A requester, running on its own clock, accepts a start command with a word address. It returns the fetched word together with a one-cycle completion pulse. A responder, running on a second and unrelated clock, holds a local storage array and answers the request. The two sides talk only through three control wires: a request wire, a data-ready wire and an acknowledge wire. They also share one group of lines that carries the address on the way out and the data word on the way back.

Each edge on the request or data-ready wire is answered by an edge on the acknowledge wire, so the exchange never depends on how fast either clock runs. Every control wire entering a clock domain first passes through a chain of at least two flip-flops. The chain depth, the storage depth and the word width are parameters. The storage array is loaded through a local fill port on the responder clock.

Top module: `async_read_link`

## Requirements
- R1: While either reset is asserted, and after it is released, the request, data-ready and acknowledge wires are low, the shared lines read all zeros, and `busy` and `done` are low.
- R2: `start` is accepted only while `busy` is low. On acceptance the request wire rises, and in the same requester cycle the shared lines carry the address, zero-extended. The lines hold that address unchanged while the request wire stays high.
- R3: A read moves the wires {request, data-ready, acknowledge} through exactly this cycle of values: 000, 100, 101, 001, 000, 010, 011, 001, and back to 000. Each change follows the other party's previous change.
- R4: At most one party drives the shared lines at a time. The responder's acknowledge and the requester's acknowledge are never both high. When neither the request wire nor the data-ready wire is high, the lines read all zeros.
- R5: While data-ready is high, the shared lines carry the stored word at the requested address, unchanged.
- R6: `done` is high for exactly one requester cycle per completed read. In that cycle `rd_data` equals the stored word at the address given with `start`, and `busy` is low.
- R7: A `start` raised while `busy` is high is ignored. The number of completions equals the number of accepted starts, and the pending read returns its own address's word.
- R8: A fill write on the responder clock replaces the stored word at `fill_addr`. A later read of that address returns the new word.
- R9: Reads complete correctly with the responder clock either slower or faster than the requester clock. Each incoming control wire crosses through `SYNC_STAGES` (at least 2) flip-flops before the state machines act on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Requester clock |
| rst_req_n | input | 1 | Requester reset, active low, asynchronous |
| start | input | 1 | Begin a read (taken only when idle) |
| addr | input | $clog2(DEPTH) | Word address for the read |
| rd_data | output | DATA_W | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A read is in progress |
| clk_rsp | input | 1 | Responder clock |
| rst_rsp_n | input | 1 | Responder reset, active low, asynchronous |
| fill_en | input | 1 | Write enable for the storage array |
| fill_addr | input | $clog2(DEPTH) | Storage write address |
| fill_data | input | DATA_W | Storage write word |
| link_req | output | 1 | Request wire, as seen on the link |
| link_rdy | output | 1 | Data-ready wire, as seen on the link |
| link_ack | output | 1 | Acknowledge wire, as seen on the link |
| link_bus | output | max($clog2(DEPTH), DATA_W) | Shared address/data lines |

## Verification
The embedded properties check, on every cycle of their own clock, the local rules of each edge. Request rises only after a start, and acknowledge rises only toward a visible request or data-ready. Data-ready rises only after both the request and the acknowledge have been seen low. Driven values stay still while their strobe is high, the two drivers never overlap, and a completion pulse lasts one cycle. These rules cannot show that the whole eight-value cycle runs in order across both domains, that the returned word matches the stored one, that an extra start is ignored, or that a fill takes effect. The bench's reference model shows these, under a slower and then a faster responder clock.

// File: rtl/link_pkg.sv
package link_pkg;

   typedef enum logic [2:0] {
      RQ_IDLE,
      RQ_ADDR,
      RQ_RELEASE,
      RQ_WAIT,
      RQ_ACK,
      RQ_CLOSE
   } rq_state_e;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_HOLD,
      RS_PREP,
      RS_SHOW,
      RS_TAIL
   } rs_state_e;

   function automatic int wider(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/link_sync.sv
module link_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("link_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("link_sync: WIDTH must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/link_requester.sv
module link_requester
   import link_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   parameter int BUS_W  = 16,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              busy,
   output logic              read_req,
   output logic              ack_out,
   output logic              drive,
   output logic [BUS_W-1:0]  bus_out,
   input  logic              ack_line,
   input  logic              rdy_line,
   input  logic [DATA_W-1:0] data_in
);

   rq_state_e         state;
   logic [ADDR_W-1:0] addr_q;
   logic              s_ack;
   logic              s_rdy;

   link_sync #(.WIDTH(2), .STAGES(STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ack_line, rdy_line}),
      .q     ({s_ack, s_rdy})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RQ_IDLE;
         read_req <= 1'b0;
         ack_out  <= 1'b0;
         done     <= 1'b0;
         addr_q   <= '0;
         rd_data  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            RQ_IDLE: if (start) begin
               addr_q   <= addr;
               read_req <= 1'b1;
               state    <= RQ_ADDR;
            end
            RQ_ADDR: if (s_ack) begin
               read_req <= 1'b0;
               state    <= RQ_RELEASE;
            end
            RQ_RELEASE: if (!s_ack) begin
               state <= RQ_WAIT;
            end
            RQ_WAIT: if (s_rdy) begin
               rd_data <= data_in;
               ack_out <= 1'b1;
               state   <= RQ_ACK;
            end
            RQ_ACK: if (!s_rdy) begin
               ack_out <= 1'b0;
               state   <= RQ_CLOSE;
            end
            RQ_CLOSE: if (!s_ack) begin
               done  <= 1'b1;
               state <= RQ_IDLE;
            end
            default: state <= RQ_IDLE;
         endcase
      end
   end

   assign busy    = (state != RQ_IDLE);
   assign drive   = (state == RQ_ADDR);
   assign bus_out = drive ? BUS_W'(addr_q) : '0;

   AST_RR_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(read_req) |-> $past(start) && !$past(busy)); // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      read_req && $past(read_req) |-> $stable(bus_out)); // R2
   AST_REQ_SIDE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(read_req && ack_out)); // R3
   AST_ACK_ANSWERS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_out) |-> s_rdy); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6

endmodule

// File: rtl/link_responder.sv
module link_responder
   import link_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   parameter int BUS_W  = 16,
   parameter int STAGES = 2,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              req_line,
   input  logic              ack_line,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              ack_out,
   output logic              data_rdy,
   output logic              drive,
   output logic [BUS_W-1:0]  bus_out
);

   rs_state_e         state;
   logic [DATA_W-1:0] store [DEPTH];
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] word_q;
   logic              s_req;
   logic              s_ack;

   link_sync #(.WIDTH(2), .STAGES(STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({req_line, ack_line}),
      .q     ({s_req, s_ack})
   );

   always_ff @(posedge clk) begin
      if (fill_en) store[fill_addr] <= fill_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RS_IDLE;
         ack_out  <= 1'b0;
         data_rdy <= 1'b0;
         addr_q   <= '0;
         word_q   <= '0;
      end else begin
         unique case (state)
            RS_IDLE: if (s_req) begin
               addr_q  <= addr_in;
               ack_out <= 1'b1;
               state   <= RS_HOLD;
            end
            RS_HOLD: if (!s_req) begin
               ack_out <= 1'b0;
               state   <= RS_PREP;
            end
            RS_PREP: if (!s_ack) begin
               word_q   <= store[addr_q];
               data_rdy <= 1'b1;
               state    <= RS_SHOW;
            end
            RS_SHOW: if (s_ack) begin
               data_rdy <= 1'b0;
               state    <= RS_TAIL;
            end
            RS_TAIL: if (!s_ack) begin
               state <= RS_IDLE;
            end
            default: state <= RS_IDLE;
         endcase
      end
   end

   assign drive   = (state == RS_SHOW);
   assign bus_out = drive ? BUS_W'(word_q) : '0;

   AST_ACK_ANSWERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_out) |-> s_req); // R3
   AST_RDY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_rdy) |-> !s_req && !s_ack); // R3
   AST_RSP_SIDE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_out && data_rdy)); // R3
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy && $past(data_rdy) |-> $stable(bus_out)); // R5

endmodule

// File: rtl/async_read_link.sv
module async_read_link
   import link_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int BUS_W  = wider(ADDR_W, DATA_W)
) (
   input  logic              clk_req,
   input  logic              rst_req_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              busy,
   input  logic              clk_rsp,
   input  logic              rst_rsp_n,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   output logic              link_req,
   output logic              link_rdy,
   output logic              link_ack,
   output logic [BUS_W-1:0]  link_bus
);

   generate
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("async_read_link: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("async_read_link: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("async_read_link: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             ack_from_req;
   logic             ack_from_rsp;
   logic             req_drive;
   logic             rsp_drive;
   logic [BUS_W-1:0] req_bus;
   logic [BUS_W-1:0] rsp_bus;

   assign link_ack = ack_from_req | ack_from_rsp;
   assign link_bus = req_bus | rsp_bus;

   link_requester #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BUS_W  (BUS_W),
      .STAGES (SYNC_STAGES)
   ) i_requester (
      .clk      (clk_req),
      .rst_n    (rst_req_n),
      .start    (start),
      .addr     (addr),
      .rd_data  (rd_data),
      .done     (done),
      .busy     (busy),
      .read_req (link_req),
      .ack_out  (ack_from_req),
      .drive    (req_drive),
      .bus_out  (req_bus),
      .ack_line (link_ack),
      .rdy_line (link_rdy),
      .data_in  (link_bus[DATA_W-1:0])
   );

   link_responder #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .BUS_W  (BUS_W),
      .STAGES (SYNC_STAGES)
   ) i_responder (
      .clk       (clk_rsp),
      .rst_n     (rst_rsp_n),
      .fill_en   (fill_en),
      .fill_addr (fill_addr),
      .fill_data (fill_data),
      .req_line  (link_req),
      .ack_line  (link_ack),
      .addr_in   (link_bus[ADDR_W-1:0]),
      .ack_out   (ack_from_rsp),
      .data_rdy  (link_rdy),
      .drive     (rsp_drive),
      .bus_out   (rsp_bus)
   );

   AST_ONE_DRIVER: assert property (@(posedge clk_req)
      disable iff (!rst_req_n || !rst_rsp_n)
      !(req_drive && rsp_drive)); // R4
   AST_ONE_ACK_OWNER: assert property (@(posedge clk_req)
      disable iff (!rst_req_n || !rst_rsp_n)
      !(ack_from_req && ack_from_rsp)); // R4

endmodule

// File: tb/test_async_read_link.sv
`timescale 1ns/1ps
module test_async_read_link;

   localparam int DEPTH  = 16;
   localparam int DATA_W = 16;
   localparam int AW     = $clog2(DEPTH);
   localparam int BUS_W  = (AW > DATA_W) ? AW : DATA_W;

   logic              clk_req = 1'b0;
   logic              clk_rsp = 1'b0;
   logic              rst_req_n = 1'b0;
   logic              rst_rsp_n = 1'b0;
   logic              start = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              done;
   logic              busy;
   logic              fill_en = 1'b0;
   logic [AW-1:0]     fill_addr = '0;
   logic [DATA_W-1:0] fill_data = '0;
   logic              link_req;
   logic              link_rdy;
   logic              link_ack;
   logic [BUS_W-1:0]  link_bus;

   int rsp_half = 8;
   always #5 clk_req = ~clk_req;
   always #(rsp_half) clk_rsp = ~clk_rsp;

   async_read_link #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SYNC_STAGES(2)) i_async_read_link (
      .clk_req   (clk_req),
      .rst_req_n (rst_req_n),
      .start     (start),
      .addr      (addr),
      .rd_data   (rd_data),
      .done      (done),
      .busy      (busy),
      .clk_rsp   (clk_rsp),
      .rst_rsp_n (rst_rsp_n),
      .fill_en   (fill_en),
      .fill_addr (fill_addr),
      .fill_data (fill_data),
      .link_req  (link_req),
      .link_rdy  (link_rdy),
      .link_ack  (link_ack),
      .link_bus  (link_bus)
   );

   int compared = 0;
   int mismatched = 0;
   int done_seen = 0;
   int accepted = 0;
   bit mon_on = 1'b0;
   bit finished = 1'b0;

   logic [DATA_W-1:0] ref_mem [DEPTH];
   logic [AW-1:0]     pend_q [$];
   logic [2:0]        seq_tab [8] = '{3'b000, 3'b100, 3'b101, 3'b001,
                                      3'b000, 3'b010, 3'b011, 3'b001};
   logic [2:0]        prev_ctl = 3'b000;
   int                seq_idx = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Reference model, compared every requester cycle away from the edge
   always @(negedge clk_req) begin
      if (mon_on && rst_req_n && rst_rsp_n) begin
         logic [2:0]    cur;
         logic [AW-1:0] front;
         cur   = {link_req, link_rdy, link_ack};
         front = (pend_q.size() > 0) ? pend_q[0] : '0;
         if (cur != prev_ctl) begin
            check(cur == seq_tab[(seq_idx + 1) % 8], "R3 control order",
                  cur, seq_tab[(seq_idx + 1) % 8]);
            seq_idx  = (seq_idx + 1) % 8;
            prev_ctl = cur;
         end
         if (link_req)
            check(link_bus == BUS_W'(front), "R2 address on lines", link_bus, BUS_W'(front));
         if (link_rdy)
            check(link_bus == BUS_W'(ref_mem[front]), "R5 word on lines",
                  link_bus, BUS_W'(ref_mem[front]));
         if (!link_req && !link_rdy)
            check(link_bus == '0, "R4 idle lines", link_bus, 0);
         if (done) begin
            done_seen++;
            check(!busy, "R6 busy low at done", busy, 0);
            if (pend_q.size() > 0) begin
               check(rd_data == ref_mem[front], "R6 returned word", rd_data, ref_mem[front]);
               void'(pend_q.pop_front());
            end else begin
               check(1'b0, "R7 completion without accepted start", 1, 0);
            end
         end
      end
   end

   task automatic issue(input int a);
      @(negedge clk_req);
      start = 1'b1;
      addr  = AW'(a);
      if (!busy) begin
         pend_q.push_back(AW'(a));
         accepted++;
      end
      @(negedge clk_req);
      start = 1'b0;
   endtask

   task automatic wait_quiet();
      int n = 0;
      do begin
         @(negedge clk_req);
         n++;
      end while ((done_seen != accepted || busy) && n < 3000);
      check(n < 3000, "R9 read finished in time", n, 3000);
   endtask

   task automatic fill(input int a, input logic [DATA_W-1:0] v);
      @(negedge clk_rsp);
      fill_en   = 1'b1;
      fill_addr = AW'(a);
      fill_data = v;
      @(negedge clk_rsp);
      fill_en = 1'b0;
      ref_mem[a] = v;
   endtask

   task automatic read_and_check(input int a, input string tag);
      issue(a);
      wait_quiet();
      check(rd_data == ref_mem[a], tag, rd_data, ref_mem[a]);
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R1: state during and after reset
      repeat (2) @(negedge clk_req);
      check({link_req, link_rdy, link_ack, busy, done} == 5'b0, "R1 in reset",
            {link_req, link_rdy, link_ack, busy, done}, 0);
      #40;
      rst_req_n = 1'b1;
      rst_rsp_n = 1'b1;
      repeat (3) @(negedge clk_req);
      check({link_req, link_rdy, link_ack, busy, done} == 5'b0, "R1 after reset",
            {link_req, link_rdy, link_ack, busy, done}, 0);
      check(link_bus == '0, "R1 lines zero", link_bus, 0);

      // R8: load storage through the fill port
      for (int i = 0; i < DEPTH; i++)
         fill(i, DATA_W'((i * 16'h1357) ^ 16'hA5C3));
      fill(0, '0);
      fill(DEPTH - 1, '1);
      mon_on = 1'b1;

      // R9: responder slower than requester
      for (int i = 0; i < DEPTH; i++)
         read_and_check(i, "R9 slow responder read");

      // R7: second start while busy is ignored
      issue(3);
      issue(9);
      wait_quiet();
      check(done_seen == accepted, "R7 one completion per accepted start", done_seen, accepted);
      check(rd_data == ref_mem[3], "R7 pending read kept its address", rd_data, ref_mem[3]);

      // R8: overwrite then read back
      fill(5, 16'hBEEF);
      read_and_check(5, "R8 overwritten word");

      // R9: responder faster than requester
      rsp_half = 2;
      repeat (4) @(negedge clk_req);
      for (int i = DEPTH - 1; i >= 0; i--)
         read_and_check(i, "R9 fast responder read");
      read_and_check(DEPTH - 1, "R5 all-ones word");
      read_and_check(0, "R5 all-zeros word");

      check(done_seen == accepted, "R7 final completion count", done_seen, accepted);
      check({link_req, link_rdy, link_ack} == 3'b000, "R3 link idle at end",
            {link_req, link_rdy, link_ack}, 0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule